// File: doc/BRIEF.md
# Memory-mapped GPIO controller

A parameterised bank of general-purpose I/O pins behind a single-cycle register port. Software writes output values and pin directions through a handful of word-wide registers. It reads back the sampled pad inputs, the output latch and the direction setting. Each pin has an output value, an output enable and a sampled input, so a tristate pad cell can be attached directly.

The output style is fixed at build time. The first style is one data register that loads every pin at once. The second is a set/clear register pair that changes only the masked pins. The third is a standalone output register, with the data offset left as a read-only input view. The direction register can be absent, or it can use either polarity. The pin-to-bit numbering can be reversed, and the byte order of bus words can be swapped for 16- and 32-bit banks. A 64-bit bank with byte swapping, or a width other than 8, 16, 32 or 64, is rejected at elaboration.

Register offsets (word addresses): 0 data, 1 set / output, 2 clear, 3 direction; offsets 4 to 7 are unmapped.

Top module: `gpio_mmio`

## Requirements
- R1: While reset is held, and on the first cycle after it, pad_out and pad_oe are all zeros and bus_rdata is zero.
- R2: In data-register style, a write to offset 0 loads the output latch of every pin, and a read of offset 0 returns the pin state as seen on pad_in.
- R3: In set/clear style, a write to offset 1 drives high every pin whose mask bit is 1 and leaves pins with a 0 mask bit unchanged.
- R4: In set/clear style, a write to offset 2 drives low every pin whose mask bit is 1 and leaves pins with a 0 mask bit unchanged.
- R5: In standalone-output style, a write to offset 1 loads the whole output latch, including clearing bits written as 0, while offset 0 is read-only and returns pad inputs.
- R6: In both styles that have offset 1, a read of offset 1 returns the output latch.
- R7: With the output-high polarity, direction bit 1 at offset 3 sets that pin's pad_oe, bit 0 clears it, and the register reads back as written; pad_oe changes only on direction writes.
- R8: With the input-high polarity, direction bit 1 clears that pin's pad_oe; the direction register resets to all ones, so every pin starts as an input.
- R9: Without a direction register, a pin's pad_oe equals its output latch bit, so a pin drives only while its latch holds 1.
- R10: pad_in passes through two flops: a change made before rising edge k is returned by a read whose enable is sampled at edge k+2, and a read sampled at edge k returns the old value.
- R11: With bit reversal, pin n uses register bit WIDTH-1-n; with byte swap, bus byte b maps to register byte WIDTH/8-1-b; with both on a 16-bit bank, pin n corresponds to bus bit 8*(n/8)+7-(n%8), so bus bit 0 is pin 7.
- R12: bus_rdata holds the value read, one cycle after the read enable is sampled, and is zero after a cycle without a read; a read and a write of the same register in one cycle return the value held before the write.
- R13: Reads of offsets 4 to 7, or of a register absent in the chosen style (offset 2 always, and offsets 1 or 3 when not configured), return zero. Writes to offsets 4 to 7, or to a register that is absent or read-only in the chosen style, leave pad_out and pad_oe unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word offset |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | WIDTH | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | WIDTH | Registered read data |
| pad_in | input | WIDTH | Raw pad inputs, asynchronous |
| pad_out | output | WIDTH | Per-pin output value |
| pad_oe | output | WIDTH | Per-pin output enable, 1 drives the pad |

## Verification
A read and a write of the set register can be issued in one cycle. When that happens, the read must return the latch as it was, and the write's effect must appear on pad_out at once. The bench raises both enables at the same edge and then compares bus_rdata with the pre-write latch and pad_out with the post-write latch. A pad change can also coincide with a data read. The bench changes pad_in in the very cycle it issues the read. It expects the stale value there, and the new value only in a read sampled two edges later.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        OUT_DATA    = 2'd0,
        OUT_SETCLR  = 2'd1,
        OUT_SETONLY = 2'd2
    } out_style_e;

    typedef enum logic [1:0] {
        DIR_NONE    = 2'd0,
        DIR_ONE_OUT = 2'd1,
        DIR_ONE_IN  = 2'd2
    } dir_style_e;

    typedef enum logic [2:0] {
        SEL_DATA = 3'd0,
        SEL_SET  = 3'd1,
        SEL_CLR  = 3'd2,
        SEL_DIR  = 3'd3,
        SEL_NONE = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_lane_map.sv
// Permutes a word between bus order and pin order. Byte swap and bit
// reversal commute and are each their own inverse, so one instance
// serves both the write and the read direction.
module gpio_lane_map #(
    parameter int WIDTH       = 32,
    parameter bit BIT_REVERSE = 1'b0,
    parameter bit BYTE_SWAP   = 1'b0
) (
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst
);
    localparam int NBYTES = WIDTH / 8;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam int BYTE_I = i / 8;
        localparam int BIT_I  = i % 8;
        localparam int SWP    = BYTE_SWAP ? ((NBYTES - 1 - BYTE_I) * 8 + BIT_I) : i;
        localparam int DST    = BIT_REVERSE ? (WIDTH - 1 - SWP) : SWP;
        assign dst[DST] = src[i];
    end
endmodule

// File: rtl/gpio_sync.sv
// Two-flop synchroniser for the raw pad inputs.
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
        end
    end

    assign synced = sync_q;
endmodule

// File: rtl/gpio_drive.sv
// Output latch and direction register, both kept in pin order.
module gpio_drive
    import gpio_pkg::*;
#(
    parameter int         WIDTH     = 32,
    parameter out_style_e OUT_STYLE = OUT_SETCLR,
    parameter dir_style_e DIR_STYLE = DIR_ONE_OUT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wval,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] oe
);
    localparam logic [WIDTH-1:0] DIR_RST = (DIR_STYLE == DIR_ONE_IN) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

    logic [WIDTH-1:0] latch_d;

    always_comb begin
        latch_d = latch_q;
        if (we) begin
            unique case (sel)
                SEL_DATA: begin
                    if (OUT_STYLE == OUT_DATA) latch_d = wval;
                end
                SEL_SET: begin
                    if (OUT_STYLE == OUT_SETCLR)       latch_d = latch_q | wval;
                    else if (OUT_STYLE == OUT_SETONLY) latch_d = wval;
                end
                SEL_CLR: begin
                    if (OUT_STYLE == OUT_SETCLR) latch_d = latch_q & ~wval;
                end
                default: latch_d = latch_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) latch_q <= '0;
        else     latch_q <= latch_d;
    end

    if (DIR_STYLE == DIR_NONE) begin : g_nodir
        assign dir_q = '0;
        assign oe    = latch_q;
    end else begin : g_dir
        logic [WIDTH-1:0] dir_r;
        always_ff @(posedge clk) begin
            if (rst)                        dir_r <= DIR_RST;
            else if (we && sel == SEL_DIR)  dir_r <= wval;
        end
        assign dir_q = dir_r;
        assign oe    = (DIR_STYLE == DIR_ONE_OUT) ? dir_r : ~dir_r;
    end
endmodule

// File: rtl/gpio_mmio.sv
module gpio_mmio
    import gpio_pkg::*;
#(
    parameter int         WIDTH       = 32,
    parameter out_style_e OUT_STYLE   = OUT_SETCLR,
    parameter dir_style_e DIR_STYLE   = DIR_ONE_OUT,
    parameter bit         BIT_REVERSE = 1'b0,
    parameter bit         BYTE_SWAP   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_re,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe
);
    if (WIDTH != 8 && WIDTH != 16 && WIDTH != 32 && WIDTH != 64) begin : g_bad_width
        $error("gpio_mmio: WIDTH must be 8, 16, 32 or 64");
    end
    if (WIDTH == 64 && BYTE_SWAP) begin : g_bad_swap
        $error("gpio_mmio: byte swap is not available for a 64-bit bank");
    end

    reg_sel_e         sel;
    logic [WIDTH-1:0] wval_pin;
    logic [WIDTH-1:0] in_sync;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] rd_pin;
    logic [WIDTH-1:0] rd_bus;
    logic [WIDTH-1:0] rdata_q;

    always_comb begin
        unique case (bus_addr)
            3'd0:    sel = SEL_DATA;
            3'd1:    sel = SEL_SET;
            3'd2:    sel = SEL_CLR;
            3'd3:    sel = SEL_DIR;
            default: sel = SEL_NONE;
        endcase
    end

    gpio_lane_map #(.WIDTH(WIDTH), .BIT_REVERSE(BIT_REVERSE), .BYTE_SWAP(BYTE_SWAP))
        u_wmap (.src(bus_wdata), .dst(wval_pin));

    gpio_sync #(.WIDTH(WIDTH))
        u_sync (.clk(clk), .rst(rst), .raw(pad_in), .synced(in_sync));

    gpio_drive #(.WIDTH(WIDTH), .OUT_STYLE(OUT_STYLE), .DIR_STYLE(DIR_STYLE))
        u_drive (
            .clk(clk), .rst(rst), .we(bus_we), .sel(sel), .wval(wval_pin),
            .latch_q(latch_q), .dir_q(dir_q), .oe(pad_oe)
        );

    always_comb begin
        rd_pin = '0;
        unique case (sel)
            SEL_DATA: rd_pin = in_sync;
            SEL_SET:  if (OUT_STYLE != OUT_DATA) rd_pin = latch_q;
            SEL_DIR:  if (DIR_STYLE != DIR_NONE) rd_pin = dir_q;
            default:  rd_pin = '0;
        endcase
    end

    gpio_lane_map #(.WIDTH(WIDTH), .BIT_REVERSE(BIT_REVERSE), .BYTE_SWAP(BYTE_SWAP))
        u_rmap (.src(rd_pin), .dst(rd_bus));

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_re) rdata_q <= rd_bus;
        else             rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;
    assign pad_out   = latch_q;
endmodule

// File: rtl/gpio_mmio_chk.sv
module gpio_mmio_chk
    import gpio_pkg::*;
#(
    parameter int         WIDTH     = 32,
    parameter out_style_e OUT_STYLE = OUT_SETCLR,
    parameter dir_style_e DIR_STYLE = DIR_ONE_OUT
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_oe
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (pad_out == '0 && pad_oe == '0 && bus_rdata == '0));

    assert_rdata_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> bus_rdata == '0);

    assert_unmapped_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr[2]) |=> ($stable(pad_out) && $stable(pad_oe)));

    if (OUT_STYLE == OUT_SETCLR) begin : g_setclr
        assert_set_no_fall_R3: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == 3'd1) |=> (($past(pad_out) & ~pad_out) == '0));

        assert_clr_no_rise_R4: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == 3'd2) |=> ((~$past(pad_out) & pad_out) == '0));
    end

    if (DIR_STYLE != DIR_NONE) begin : g_dir
        // Covers R8 as well: either polarity only moves pad_oe on a direction write.
        assert_dir_hold_R7: assert property (@(posedge clk) disable iff (rst)
            !(bus_we && bus_addr == 3'd3) |=> $stable(pad_oe));
    end
endmodule

bind gpio_mmio gpio_mmio_chk #(
    .WIDTH(WIDTH), .OUT_STYLE(OUT_STYLE), .DIR_STYLE(DIR_STYLE)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/tb_gpio_mmio.sv
module tb_gpio_mmio;
    import gpio_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;
    logic rst = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Unit A: 16-bit, set/clear, 1 = output, reversed bits, swapped bytes
    logic [2:0]  a_addr = '0;
    logic        a_we = 1'b0, a_re = 1'b0;
    logic [15:0] a_wdata = '0, a_ext = '0;
    logic [15:0] a_rdata, a_out, a_oe, a_pin;
    assign a_pin = (a_oe & a_out) | (~a_oe & a_ext);

    gpio_mmio #(.WIDTH(16), .OUT_STYLE(OUT_SETCLR), .DIR_STYLE(DIR_ONE_OUT),
                .BIT_REVERSE(1'b1), .BYTE_SWAP(1'b1)) dut (
        .clk(clk), .rst(rst), .bus_addr(a_addr), .bus_we(a_we), .bus_wdata(a_wdata),
        .bus_re(a_re), .bus_rdata(a_rdata), .pad_in(a_pin), .pad_out(a_out), .pad_oe(a_oe));

    // Unit B: 8-bit, data register, 1 = input
    logic [2:0] b_addr = '0;
    logic       b_we = 1'b0, b_re = 1'b0;
    logic [7:0] b_wdata = '0, b_ext = '0;
    logic [7:0] b_rdata, b_out, b_oe, b_pin;
    assign b_pin = (b_oe & b_out) | (~b_oe & b_ext);

    gpio_mmio #(.WIDTH(8), .OUT_STYLE(OUT_DATA), .DIR_STYLE(DIR_ONE_IN),
                .BIT_REVERSE(1'b0), .BYTE_SWAP(1'b0)) dut_b (
        .clk(clk), .rst(rst), .bus_addr(b_addr), .bus_we(b_we), .bus_wdata(b_wdata),
        .bus_re(b_re), .bus_rdata(b_rdata), .pad_in(b_pin), .pad_out(b_out), .pad_oe(b_oe));

    // Unit C: 8-bit, standalone output register, no direction register
    logic [2:0] c_addr = '0;
    logic       c_we = 1'b0, c_re = 1'b0;
    logic [7:0] c_wdata = '0, c_ext = '0;
    logic [7:0] c_rdata, c_out, c_oe, c_pin;
    assign c_pin = (c_oe & c_out) | (~c_oe & c_ext);

    gpio_mmio #(.WIDTH(8), .OUT_STYLE(OUT_SETONLY), .DIR_STYLE(DIR_NONE),
                .BIT_REVERSE(1'b0), .BYTE_SWAP(1'b0)) dut_c (
        .clk(clk), .rst(rst), .bus_addr(c_addr), .bus_we(c_we), .bus_wdata(c_wdata),
        .bus_re(c_re), .bus_rdata(c_rdata), .pad_in(c_pin), .pad_out(c_out), .pad_oe(c_oe));

    // Pin n of unit A <-> bus bit 8*(n/8)+7-(n%8)  (R11)
    function automatic logic [15:0] amap(input logic [15:0] x);
        logic [15:0] r;
        for (int n = 0; n < 16; n++) r[n] = x[8 * (n / 8) + 7 - (n % 8)];
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic bus_wr(input int u, input logic [2:0] ad, input logic [15:0] d);
        @(negedge clk);
        case (u)
            0:       begin a_addr = ad; a_wdata = d;      a_we = 1'b1; end
            1:       begin b_addr = ad; b_wdata = d[7:0]; b_we = 1'b1; end
            default: begin c_addr = ad; c_wdata = d[7:0]; c_we = 1'b1; end
        endcase
        @(negedge clk);
        a_we = 1'b0; b_we = 1'b0; c_we = 1'b0;
    endtask

    task automatic bus_rd(input int u, input logic [2:0] ad, output logic [15:0] d);
        @(negedge clk);
        case (u)
            0:       begin a_addr = ad; a_re = 1'b1; end
            1:       begin b_addr = ad; b_re = 1'b1; end
            default: begin c_addr = ad; c_re = 1'b1; end
        endcase
        @(negedge clk);
        a_re = 1'b0; b_re = 1'b0; c_re = 1'b0;
        case (u)
            0:       d = a_rdata;
            1:       d = {8'h00, b_rdata};
            default: d = {8'h00, c_rdata};
        endcase
    endtask

    logic [15:0] la;  // model of unit A latch, pin order

    task automatic t_reset();
        logic [15:0] v;
        check("R1", "A pad_out after reset", a_out, 16'h0000);
        check("R1", "A pad_oe after reset", a_oe, 16'h0000);
        check("R1", "A rdata after reset", a_rdata, 16'h0000);
        check("R1", "B pad_oe after reset", {8'h00, b_oe}, 16'h0000);
        check("R1", "C pad_out after reset", {8'h00, c_out}, 16'h0000);
        bus_rd(0, 3'd1, v);
        check("R1", "A latch readback after reset", v, 16'h0000);
    endtask

    task automatic t_setclr();
        logic [15:0] v;
        la = '0;
        bus_wr(0, 3'd1, 16'h00F0);
        la = la | amap(16'h00F0);
        check("R3", "set mask 00F0", a_out, la);
        check("R11", "bus bits 7..4 land on pins 0..3", a_out, 16'h000F);
        bus_wr(0, 3'd1, 16'h8100);
        la = la | amap(16'h8100);
        check("R3", "second set keeps earlier pins", a_out, 16'h810F);
        bus_wr(0, 3'd2, 16'h0030);
        la = la & ~amap(16'h0030);
        check("R4", "clear mask 0030", a_out, la);
        bus_wr(0, 3'd2, 16'h0000);
        check("R4", "empty clear mask changes nothing", a_out, 16'h8103);
        bus_rd(0, 3'd1, v);
        check("R6", "latch readback in bus order", v, 16'h81C0);
    endtask

    task automatic t_dir_a();
        logic [15:0] v;
        bus_wr(0, 3'd3, 16'h0001);
        check("R11", "direction bus bit 0 is pin 7", a_oe, 16'h0080);
        bus_wr(0, 3'd3, 16'h00FF);
        check("R7", "direction 1 = output", a_oe, 16'h00FF);
        bus_rd(0, 3'd3, v);
        check("R7", "direction readback", v, 16'h00FF);
        check("R7", "pad_out untouched by direction write", a_out, 16'h8103);
    endtask

    task automatic t_sync();
        logic [15:0] old_bus;
        old_bus = amap(a_pin);
        @(negedge clk);
        a_ext = 16'h3100;
        a_addr = 3'd0; a_re = 1'b1;
        @(negedge clk);
        a_re = 1'b0;
        check("R10", "read sampled at first edge shows old pins", a_rdata, old_bus);
        @(negedge clk);
        a_addr = 3'd0; a_re = 1'b1;
        @(negedge clk);
        a_re = 1'b0;
        check("R10", "read sampled at third edge shows new pins", a_rdata, amap(16'h3103));
        check("R10", "new pins value in bus order", a_rdata, 16'h8CC0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        a_addr = 3'd1; a_wdata = 16'h0002; a_we = 1'b1; a_re = 1'b1;
        @(negedge clk);
        a_we = 1'b0; a_re = 1'b0;
        check("R12", "read beside write returns pre-write latch", a_rdata, 16'h81C0);
        check("R12", "write beside read takes effect", a_out, 16'h8143);
        @(negedge clk);
        check("R12", "rdata zero after idle cycle", a_rdata, 16'h0000);
    endtask

    task automatic t_unmapped();
        logic [15:0] v;
        bus_wr(0, 3'd5, 16'hFFFF);
        check("R13", "unmapped write leaves pad_out", a_out, 16'h8143);
        check("R13", "unmapped write leaves pad_oe", a_oe, 16'h00FF);
        bus_wr(0, 3'd0, 16'hFFFF);
        check("R13", "data write ignored in set/clear style", a_out, 16'h8143);
        bus_rd(0, 3'd6, v);
        check("R13", "unmapped read", v, 16'h0000);
        bus_rd(0, 3'd2, v);
        check("R13", "clear register reads zero", v, 16'h0000);
    endtask

    task automatic t_unit_b();
        logic [15:0] v;
        bus_rd(1, 3'd3, v);
        check("R8", "input-high direction resets to ones", v, 16'h00FF);
        check("R8", "all pins inputs after reset", {8'h00, b_oe}, 16'h0000);
        bus_wr(1, 3'd0, 16'h005A);
        check("R2", "data write loads every pin", {8'h00, b_out}, 16'h005A);
        bus_wr(1, 3'd3, 16'h00F0);
        check("R8", "direction 1 = input", {8'h00, b_oe}, 16'h000F);
        @(negedge clk);
        b_ext = 8'hC3;
        repeat (3) @(negedge clk);
        bus_rd(1, 3'd0, v);
        check("R2", "data read returns pin state", v, 16'h00CA);
        bus_wr(1, 3'd1, 16'h00FF);
        check("R13", "set write ignored in data style", {8'h00, b_out}, 16'h005A);
        bus_rd(1, 3'd1, v);
        check("R13", "absent set register reads zero", v, 16'h0000);
    endtask

    task automatic t_unit_c();
        logic [15:0] v;
        bus_wr(2, 3'd1, 16'h003C);
        check("R5", "output register load", {8'h00, c_out}, 16'h003C);
        check("R9", "oe follows latch", {8'h00, c_oe}, 16'h003C);
        bus_wr(2, 3'd1, 16'h0001);
        check("R5", "whole-register load clears zeros", {8'h00, c_out}, 16'h0001);
        check("R9", "oe follows latch after reload", {8'h00, c_oe}, 16'h0001);
        bus_rd(2, 3'd1, v);
        check("R6", "output register readback", v, 16'h0001);
        @(negedge clk);
        c_ext = 8'h80;
        repeat (3) @(negedge clk);
        bus_rd(2, 3'd0, v);
        check("R5", "data offset returns inputs", v, 16'h0081);
        bus_wr(2, 3'd0, 16'h00FF);
        check("R5", "data offset is read-only", {8'h00, c_out}, 16'h0001);
        bus_rd(2, 3'd3, v);
        check("R13", "absent direction register reads zero", v, 16'h0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_setclr();
        t_dir_a();
        t_sync();
        t_same_cycle();
        t_unmapped();
        t_unit_b();
        t_unit_c();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual 20000 cycles expected completion earlier");
            report();
            $finish;
        end
    end
endmodule